// File: doc/BRIEF.md
# Coherent Two-Byte Measurement Read Path

This block serves the byte reads of a serial host transaction for four 16-bit measurement register pairs: voltage, current, accumulated current and temperature. Measurement logic drives the voltage, current and temperature words continuously, and they may change on any cycle. The accumulated-current word is held inside the block. The measurement side can reload it, and the host can overwrite it.

A transaction opens with a start strobe that carries a byte address. Each byte read or byte write then uses the current address and advances it by one. The transaction closes with an end strobe. Each pair keeps its high byte at the even (lower) address. Reading the high byte freezes the whole 16-bit word of that pair. The low byte that follows in the same transaction therefore belongs to the same sample, even if the live value has moved on. Every frozen word is dropped when the transaction closes.

Host writes reach only the accumulated-current pair. A high-byte write is staged, and the low-byte write puts both bytes into the register in one step.

Top module: `snapReadPath`

## Requirements
- R1: Pair byte addresses are voltage 0Ch/0Dh, current 0Eh/0Fh, accumulated current 10h/11h and temperature 18h/19h, with bits [15:8] at the even address. `rdData` carries the byte and `rdValid` is high exactly one cycle after an accepted `rdReq`.
- R2: `txnStart` loads `startAddr` as the current address. Each accepted `rdReq` or `wrReq` advances the address by one, modulo 256.
- R3: A high-byte read captures the full 16-bit word of that pair from the values present in the same cycle, and returns the high byte of that word.
- R4: Once a pair is captured, later reads of either of its bytes in the same transaction return the captured word, whatever the live value does.
- R5: A low-byte read with no earlier high-byte read of that pair in the transaction returns the live low byte.
- R6: `txnEnd` and `txnStart` discard all captured words and any staged write byte, so the next transaction reads live values.
- R7: Any address outside the eight pair bytes reads as 00h.
- R8: A write to 10h only stages a byte and leaves `accValue` unchanged. A write to 11h sets `accValue` one cycle later to {staged byte, written byte}, or to {current high byte, written byte} when nothing is staged.
- R9: Writes to any address other than 10h/11h have no effect on `accValue` or on the values later read back.
- R10: `accLoad` loads `accLoadVal` into `accValue` one cycle later. When an 11h write commits in the same cycle, the host value wins.
- R11: `rdReq` and `wrReq` outside a transaction, or in the `txnStart` cycle, are ignored: `rdValid` stays low and the address does not move.
- R12: After reset `rdValid` is 0, `rdData` is 00h, `accValue` is 0000h, no transaction is open and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| txnStart | input | 1 | Opens a transaction at `startAddr` |
| txnEnd | input | 1 | Closes the transaction and releases captures |
| startAddr | input | 8 | First byte address of the transaction |
| rdReq | input | 1 | Read the byte at the current address |
| wrReq | input | 1 | Write `wrData` at the current address |
| wrData | input | 8 | Host write byte |
| liveVolt | input | 16 | Live voltage word |
| liveCurr | input | 16 | Live current word |
| liveTemp | input | 16 | Live temperature word |
| accLoad | input | 1 | Measurement-side reload of the accumulated word |
| accLoadVal | input | 16 | Value for `accLoad` |
| rdData | output | 8 | Read byte, registered |
| rdValid | output | 1 | `rdData` updated this cycle |
| accValue | output | 16 | Current accumulated-current word |

## Verification
Two pairs of events can fall on the same clock edge. A live word can change in the same cycle as its high-byte capture, and a measurement reload can arrive in the same cycle as a host low-byte commit. Directed cases line each pair up deliberately. A live voltage update is followed by a high-byte read and then a new live value before the low-byte read, and `accLoad` is raised together with an 11h write. Random transactions mix reads, writes, reloads and live updates on their own schedule. Every byte read back and every `accValue` is compared against a bench model written from the requirements.

// File: rtl/snapRdPkg.sv
package snapRdPkg;
  localparam int NumPairs = 4;

  typedef enum logic [1:0] {PairVolt, PairCurr, PairAcc, PairTemp} pairSel_t;

  typedef struct packed {
    logic     readEn;
    logic     pairHit;
    pairSel_t pair;
    logic     lowByte;
    logic     releaseAll;
    logic     stageMsb;
    logic     commitLsb;
  } dpStrobe_t;
endpackage

// File: rtl/snapRdCtrl.sv
module snapRdCtrl
  import snapRdPkg::*;
#(
  parameter int AddrW = 8,
  parameter logic [AddrW-1:0] VoltBase = 'h0C,
  parameter logic [AddrW-1:0] CurrBase = 'h0E,
  parameter logic [AddrW-1:0] AccBase  = 'h10,
  parameter logic [AddrW-1:0] TempBase = 'h18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txnStart,
  input  logic             txnEnd,
  input  logic [AddrW-1:0] startAddr,
  input  logic             rdReq,
  input  logic             wrReq,
  output dpStrobe_t        strobe,
  output logic [AddrW-1:0] curPtr,
  output logic             inTxn
);
  localparam logic [NumPairs-1:0][AddrW-1:0] Bases = {TempBase, AccBase, CurrBase, VoltBase};

  logic [AddrW-1:0] ptrQ;
  logic             inTxnQ;
  logic             access;
  logic             doWrite;
  logic             hit;
  pairSel_t         sel;

  assign access  = (rdReq || wrReq) && inTxnQ && !txnStart;
  assign doWrite = access && wrReq && !rdReq;

  // Pair decode: a pair occupies an even/odd address couple.
  always_comb begin
    hit = 1'b0;
    sel = PairVolt;
    for (int i = 0; i < NumPairs; i++) begin
      if (ptrQ[AddrW-1:1] == Bases[i][AddrW-1:1]) begin
        hit = 1'b1;
        sel = pairSel_t'(i);
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.readEn     = access && rdReq;
    strobe.pairHit    = hit;
    strobe.pair       = sel;
    strobe.lowByte    = ptrQ[0];
    strobe.releaseAll = txnStart || txnEnd;
    strobe.stageMsb   = doWrite && hit && (sel == PairAcc) && !ptrQ[0];
    strobe.commitLsb  = doWrite && hit && (sel == PairAcc) && ptrQ[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      inTxnQ <= 1'b0;
    end else begin
      if (txnStart)    ptrQ <= startAddr;
      else if (access) ptrQ <= ptrQ + 1'b1;
      if (txnStart)    inTxnQ <= 1'b1;
      else if (txnEnd) inTxnQ <= 1'b0;
    end
  end

  assign curPtr = ptrQ;
  assign inTxn  = inTxnQ;
endmodule

// File: rtl/snapRdDatapath.sv
module snapRdDatapath
  import snapRdPkg::*;
#(
  parameter int ByteW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [ByteW-1:0]     wrData,
  input  logic [2*ByteW-1:0]   liveVolt,
  input  logic [2*ByteW-1:0]   liveCurr,
  input  logic [2*ByteW-1:0]   liveTemp,
  input  logic                 accLoad,
  input  logic [2*ByteW-1:0]   accLoadVal,
  output logic [ByteW-1:0]     rdData,
  output logic                 rdValid,
  output logic [2*ByteW-1:0]   accValue
);
  localparam int WordW = 2 * ByteW;

  logic [WordW-1:0]                 accQ;
  logic [ByteW-1:0]                 stagedMsbQ;
  logic                             stagedValidQ;
  logic [NumPairs-1:0][WordW-1:0]   liveW;
  logic [NumPairs-1:0][WordW-1:0]   snapQ;
  logic [NumPairs-1:0]              snapValidQ;
  logic [NumPairs-1:0]              captureEn;
  logic [WordW-1:0]                 commitVal;
  logic [WordW-1:0]                 selWord;
  logic [ByteW-1:0]                 selByte;

  assign liveW = {liveTemp, accQ, liveCurr, liveVolt};

  for (genvar g = 0; g < NumPairs; g++) begin : g_cap
    assign captureEn[g] = strobe.readEn && strobe.pairHit && !strobe.lowByte &&
                          (strobe.pair == pairSel_t'(g)) && !snapValidQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ      <= '0;
      snapValidQ <= '0;
    end else begin
      for (int i = 0; i < NumPairs; i++) begin
        if (strobe.releaseAll) begin
          snapValidQ[i] <= 1'b0;
        end else if (captureEn[i]) begin
          snapValidQ[i] <= 1'b1;
          snapQ[i]      <= liveW[i];
        end
      end
    end
  end

  assign commitVal = {(stagedValidQ ? stagedMsbQ : accQ[WordW-1:ByteW]), wrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ         <= '0;
      stagedMsbQ   <= '0;
      stagedValidQ <= 1'b0;
    end else begin
      if (strobe.commitLsb) accQ <= commitVal;
      else if (accLoad)     accQ <= accLoadVal;
      if (strobe.releaseAll || strobe.commitLsb) begin
        stagedValidQ <= 1'b0;
      end else if (strobe.stageMsb) begin
        stagedValidQ <= 1'b1;
        stagedMsbQ   <= wrData;
      end
    end
  end

  always_comb begin
    selWord = snapValidQ[strobe.pair] ? snapQ[strobe.pair] : liveW[strobe.pair];
    selByte = strobe.lowByte ? selWord[ByteW-1:0] : selWord[WordW-1:ByteW];
    if (!strobe.pairHit) selByte = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.readEn;
      if (strobe.readEn) rdData <= selByte;
    end
  end

  assign accValue = accQ;
endmodule

// File: rtl/snapReadPath.sv
module snapReadPath
  import snapRdPkg::*;
#(
  parameter int AddrW = 8,
  parameter int ByteW = 8,
  parameter logic [AddrW-1:0] VoltBase = 'h0C,
  parameter logic [AddrW-1:0] CurrBase = 'h0E,
  parameter logic [AddrW-1:0] AccBase  = 'h10,
  parameter logic [AddrW-1:0] TempBase = 'h18
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txnStart,
  input  logic               txnEnd,
  input  logic [AddrW-1:0]   startAddr,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [ByteW-1:0]   wrData,
  input  logic [2*ByteW-1:0] liveVolt,
  input  logic [2*ByteW-1:0] liveCurr,
  input  logic [2*ByteW-1:0] liveTemp,
  input  logic               accLoad,
  input  logic [2*ByteW-1:0] accLoadVal,
  output logic [ByteW-1:0]   rdData,
  output logic               rdValid,
  output logic [2*ByteW-1:0] accValue
);
  dpStrobe_t        strobe;
  logic [AddrW-1:0] curPtr;
  logic             inTxn;

  snapRdCtrl #(
    .AddrW(AddrW), .VoltBase(VoltBase), .CurrBase(CurrBase),
    .AccBase(AccBase), .TempBase(TempBase)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnEnd(txnEnd),
    .startAddr(startAddr), .rdReq(rdReq), .wrReq(wrReq),
    .strobe(strobe), .curPtr(curPtr), .inTxn(inTxn)
  );

  snapRdDatapath #(.ByteW(ByteW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .liveVolt(liveVolt), .liveCurr(liveCurr), .liveTemp(liveTemp),
    .accLoad(accLoad), .accLoadVal(accLoadVal),
    .rdData(rdData), .rdValid(rdValid), .accValue(accValue)
  );
endmodule

// File: rtl/snapReadPath_chk.sv
module snapReadPath_chk #(
  parameter int AddrW = 8,
  parameter int ByteW = 8,
  parameter logic [AddrW-1:0] VoltBase = 'h0C,
  parameter logic [AddrW-1:0] CurrBase = 'h0E,
  parameter logic [AddrW-1:0] AccBase  = 'h10,
  parameter logic [AddrW-1:0] TempBase = 'h18
) (
  input logic               clk,
  input logic               rstN,
  input logic               txnStart,
  input logic               rdReq,
  input logic               wrReq,
  input logic               accLoad,
  input logic               rdValid,
  input logic [ByteW-1:0]   rdData,
  input logic [2*ByteW-1:0] accValue,
  input logic [AddrW-1:0]   curPtr,
  input logic               inTxn
);
  logic backed;
  assign backed = (curPtr == VoltBase) || (curPtr == VoltBase + 1'b1) ||
                  (curPtr == CurrBase) || (curPtr == CurrBase + 1'b1) ||
                  (curPtr == AccBase)  || (curPtr == AccBase + 1'b1)  ||
                  (curPtr == TempBase) || (curPtr == TempBase + 1'b1);

  // R1
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq && inTxn && !txnStart));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq || wrReq) && inTxn && !txnStart) |=> (curPtr == AddrW'($past(curPtr) + 1'b1)));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && inTxn && !txnStart && !backed) |=> (rdData == '0));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accLoad && !wrReq) |=> $stable(accValue));

  // R11
  rd_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !inTxn) |=> !rdValid);
endmodule

bind snapReadPath snapReadPath_chk #(
  .AddrW(AddrW), .ByteW(ByteW), .VoltBase(VoltBase), .CurrBase(CurrBase),
  .AccBase(AccBase), .TempBase(TempBase)
) u_chk (
  .clk(clk), .rstN(rstN), .txnStart(txnStart), .rdReq(rdReq), .wrReq(wrReq),
  .accLoad(accLoad), .rdValid(rdValid), .rdData(rdData), .accValue(accValue),
  .curPtr(curPtr), .inTxn(inTxn)
);

// File: tb/snapReadPath_tb.sv
module snapReadPath_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnStart = 1'b0, txnEnd = 1'b0, rdReq = 1'b0, wrReq = 1'b0, accLoad = 1'b0;
  logic [7:0]  startAddr = '0, wrData = '0;
  logic [15:0] liveVolt = '0, liveCurr = '0, liveTemp = '0, accLoadVal = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [15:0] accValue;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model
  logic [15:0] mAcc = '0;
  logic [15:0] mSnap [4];
  bit          mSnapV [4];
  logic [7:0]  mPtr = '0;
  bit          mInTxn = 0;
  logic [7:0]  mStage = '0;
  bit          mStageV = 0;

  always #10 clk = ~clk;

  snapReadPath u_dut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnEnd(txnEnd), .startAddr(startAddr),
    .rdReq(rdReq), .wrReq(wrReq), .wrData(wrData), .liveVolt(liveVolt),
    .liveCurr(liveCurr), .liveTemp(liveTemp), .accLoad(accLoad), .accLoadVal(accLoadVal),
    .rdData(rdData), .rdValid(rdValid), .accValue(accValue)
  );

  function automatic int pairOf(input logic [7:0] a);
    case (a[7:1])
      7'h06:   return 0;
      7'h07:   return 1;
      7'h08:   return 2;
      7'h0C:   return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] liveOf(input int p);
    case (p)
      0:       return liveVolt;
      1:       return liveCurr;
      2:       return mAcc;
      default: return liveTemp;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearSnaps();
    for (int i = 0; i < 4; i++) mSnapV[i] = 0;
    mStageV = 0;
  endtask

  task automatic startTxn(input logic [7:0] a);
    txnStart = 1; startAddr = a;
    mPtr = a; mInTxn = 1; clearSnaps();
    @(negedge clk);
    txnStart = 0;
  endtask

  task automatic endTxn();
    txnEnd = 1;
    mInTxn = 0; clearSnaps();
    @(negedge clk);
    txnEnd = 0;
  endtask

  task automatic readByte(input string forceTag);
    int p;
    logic [15:0] w;
    logic [7:0] exp;
    string tag;
    bit ok;
    ok = mInTxn;
    p = pairOf(mPtr);
    exp = 8'h00;
    tag = "R7";
    if (p >= 0) begin
      w = mSnapV[p] ? mSnap[p] : liveOf(p);
      exp = mPtr[0] ? w[7:0] : w[15:8];
      tag = mPtr[0] ? (mSnapV[p] ? "R4" : "R5") : (mSnapV[p] ? "R4" : "R3");
      if (ok && !mPtr[0] && !mSnapV[p]) begin mSnap[p] = liveOf(p); mSnapV[p] = 1; end
    end
    if (forceTag != "") tag = forceTag;
    rdReq = 1;
    @(negedge clk);
    rdReq = 0;
    if (ok) begin
      check({tag, " valid"}, rdValid, 1);
      check({tag, " data"}, rdData, exp);
      mPtr++;
    end else begin
      check("R11 valid", rdValid, 0);
    end
  endtask

  task automatic writeByte(input logic [7:0] d, input bit load, input logic [15:0] lv);
    bit commit;
    commit = 0;
    if (mInTxn) begin
      if (mPtr == 8'h10) begin mStage = d; mStageV = 1; end
      else if (mPtr == 8'h11) begin
        mAcc = {(mStageV ? mStage : mAcc[15:8]), d}; mStageV = 0; commit = 1;
      end
      mPtr++;
    end
    if (load && !commit) mAcc = lv;
    wrReq = 1; wrData = d; accLoad = load; accLoadVal = lv;
    @(negedge clk);
    wrReq = 0; accLoad = 0;
    check(commit ? (load ? "R10 acc" : "R8 acc") : "R9 acc", accValue, mAcc);
  endtask

  task automatic loadAcc(input logic [15:0] v);
    accLoad = 1; accLoadVal = v; mAcc = v;
    @(negedge clk);
    accLoad = 0;
    check("R10 load", accValue, mAcc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    clearSnaps();
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 rdValid", rdValid, 0);
    check("R12 rdData", rdData, 0);
    check("R12 accValue", accValue, 0);
    rstN = 1;
    @(negedge clk);

    // R1 byte order, R2 address advance from a reserved start
    liveVolt = 16'hA1B2; liveCurr = 16'hC3D4; liveTemp = 16'hE5F6;
    startTxn(8'h0B);
    readByte("R7");
    readByte("R1");
    readByte("R2");
    endTxn();

    // R4 tearing: live changes between high and low byte
    startTxn(8'h0C);
    liveVolt = 16'h1234;
    readByte("R3");
    liveVolt = 16'h5678;
    readByte("R4");
    startTxn(8'h0C);      // R6 restart releases
    readByte("R6");
    endTxn();

    // R5 low byte alone reads live
    startTxn(8'h19);
    liveTemp = 16'h9ABC;
    readByte("R5");
    endTxn();

    // R11 read outside a transaction
    readByte("R11");

    // R8 staged write, R9 write to read-only
    startTxn(8'h0E);
    writeByte(8'h77, 0, 16'h0);
    writeByte(8'h66, 0, 16'h0);
    writeByte(8'hAB, 0, 16'h0);
    writeByte(8'hCD, 0, 16'h0);
    endTxn();
    startTxn(8'h0E);
    readByte("R9");
    readByte("R9");
    readByte("R8");
    readByte("R8");
    endTxn();

    // R8 low byte only, R10 collision
    startTxn(8'h11);
    writeByte(8'h3C, 1, 16'hFFFF);
    endTxn();
    loadAcc(16'h4242);
    startTxn(8'h10);
    readByte("R10");
    readByte("R10");
    endTxn();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 2) == 0) begin
        liveVolt = 16'($urandom); liveCurr = 16'($urandom); liveTemp = 16'($urandom);
      end
      case (op)
        0:          startTxn(8'($urandom_range(8'h0A, 8'h1B)));
        1:          endTxn();
        2, 3, 4, 5: readByte("");
        6, 7:       writeByte(8'($urandom), ($urandom_range(0, 3) == 0), 16'($urandom));
        default:    loadAcc(16'($urandom));
      endcase
    end
    endTxn();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule